// File: doc/BRIEF.md
# Pad Bias, Drive and Schmitt Configuration Bank

This block holds the electrical settings of a bank of pads: a two-bit bias code per pin, a drive-strength code per pin and a Schmitt-trigger enable per pin. Software programs it through a plain write port whose 32-bit word carries a 16-bit value in its low half and a 16-bit bit-enable in its high half. A write changes only the value bits whose enable bit is set, so a field can be updated without reading the register first. The stored settings are decoded at once into flat per-pin buses that go to the pad ring.

Pins come in groups of eight. Each group has either an ordinary pad type with a 2-bit drive code or a wide-range pad type with a 3-bit drive code, chosen per group by a parameter. A wide-range group spreads its eight 3-bit codes over two consecutive registers, so one code straddles the register boundary and is rebuilt from both. The write port has no back-pressure: every enabled write to a mapped address takes effect at the next clock edge, and the port has no ready signal because it never stalls.

Top module: `padcfg_bank`

## Requirements
- R1: Reset (synchronous, active high) clears every register; afterwards every bias, drive and Schmitt output is 0.
- R2: A write stores value bit i (wr_data[i], i in 0..15) only when enable bit wr_data[16+i] is 1; other bits keep their value, so a write with all enable bits 0 changes nothing and a partial enable changes only the enabled bits.
- R3: Bias codes live at word addresses 0 .. NUM_PINS/8-1: pin p uses address p/8, bits 2*(p%8)+1 : 2*(p%8). The code appears unchanged on bias_o[2p+:2] (0 no bias, 1 pull-up, 2 pull-down, 3 bus-hold); a write to these addresses does not move drive or Schmitt outputs.
- R4: Schmitt enables follow at addresses NUM_PINS/8 onward: pin p uses address NUM_PINS/8 + p/16, bit p%16, shown on schmitt_o[p].
- R5: Drive registers start at address NUM_PINS/8 + NUM_PINS/16; group g's base is that start plus, for each lower group, 2 if it is wide-range and 1 if not. In an ordinary group pin k (k = p%8) uses base bits 2k+1:2k, and drive_o[3p+2] is 0.
- R6: In a wide-range group the two registers form a 32-bit span (base low, base+1 high); pin k's 3-bit code sits at span bits 3k+2:3k, so pins 0 to 4 lie wholly in the base register.
- R7: Pin 5 of a wide-range group is split: code bit 0 is base register bit 15, code bits 2:1 are bits 1:0 of register base+1, and the output shows all three bits together.
- R8: Pins 6 and 7 of a wide-range group lie wholly in register base+1 at bits 4:2 and 7:5.
- R9: A write with wr_en low, or to an address at or above the register count, changes no output.
- R10: Outputs reflect a write from the clock edge that captures it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word address of the register written |
| wr_data | input | 32 | High half: bit-enables; low half: values |
| bias_o | output | 2*NUM_PINS | Per-pin bias code |
| drive_o | output | 3*NUM_PINS | Per-pin drive code, MSB 0 for ordinary groups |
| schmitt_o | output | NUM_PINS | Per-pin Schmitt enable |

## Verification
The bench builds the block with 32 pins, a 4-bit address and the group pattern 4'b0110, so two ordinary groups sit around two wide-range groups: the drive bases then shift by one and two words, both split codes exist, and four of the sixteen addresses are unmapped. With only twelve registers it can sweep every address with many pseudo-random value and enable patterns and compare all 96 pin fields after each write against a bit-level model built from the address and bit formulas. Directed writes cover the split code, zero and partial enables, unmapped addresses and an idle strobe.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;
  localparam int GRP_PINS   = 8;
  localparam int WORD_W     = 16;
  localparam int BIAS_W     = 2;
  localparam int DRV_W      = 3;

  // first drive word of group grp
  function automatic int drv_base(input logic [31:0] wide, input int grp, input int pins);
    int b;
    b = pins / 8 + pins / 16;
    for (int j = 0; j < grp; j++) b += wide[j] ? 2 : 1;
    return b;
  endfunction

  function automatic int reg_count(input logic [31:0] wide, input int pins);
    return drv_base(wide, pins / 8, pins);
  endfunction
endpackage

// File: rtl/padcfg_regfile.sv
module padcfg_regfile #(
  parameter int NREG   = 12,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [31:0]                    wr_data,
  output logic [NREG*padcfg_pkg::WORD_W-1:0] words_o
);
  localparam int W = padcfg_pkg::WORD_W;

  logic [W-1:0] mem [NREG];
  logic [W-1:0] en_bits, val_bits;
  logic         hit;

  assign en_bits  = wr_data[2*W-1:W];
  assign val_bits = wr_data[W-1:0];
  assign hit      = wr_en && (int'(wr_addr) < NREG);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (hit) begin
      mem[wr_addr] <= (mem[wr_addr] & ~en_bits) | (val_bits & en_bits);
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_flat
    assign words_o[i*W +: W] = mem[i];
  end
endmodule

// File: rtl/padcfg_wide_group.sv
module padcfg_wide_group (
  input  logic [23:0] span_i,
  output logic [23:0] codes_o
);
  // pin k occupies span bits 3k+2:3k; pin 5 crosses the word boundary
  for (genvar k = 0; k < padcfg_pkg::GRP_PINS; k++) begin : g_pin
    if (k == 5) begin : g_split
      assign codes_o[3*k +: 3] = {span_i[17:16], span_i[15]};
    end else begin : g_whole
      assign codes_o[3*k +: 3] = span_i[3*k +: 3];
    end
  end
endmodule

// File: rtl/padcfg_bank.sv
module padcfg_bank #(
  parameter int                    NUM_PINS  = 32,
  parameter logic [NUM_PINS/8-1:0] WIDE_MASK = 4'b0110,
  parameter int                    ADDR_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  output logic [2*NUM_PINS-1:0] bias_o,
  output logic [3*NUM_PINS-1:0] drive_o,
  output logic [NUM_PINS-1:0]   schmitt_o
);
  import padcfg_pkg::*;

  localparam int NGRP      = NUM_PINS / GRP_PINS;
  localparam int NBIAS     = NUM_PINS / 8;
  localparam int NSCH      = NUM_PINS / 16;
  localparam int NREG      = reg_count(32'(WIDE_MASK), NUM_PINS);

  logic [NREG*WORD_W-1:0] words;

  padcfg_regfile #(.NREG(NREG), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .words_o (words)
  );

  for (genvar r = 0; r < NBIAS; r++) begin : g_bias
    assign bias_o[r*WORD_W +: WORD_W] = words[r*WORD_W +: WORD_W];
  end

  for (genvar s = 0; s < NSCH; s++) begin : g_sch
    assign schmitt_o[s*WORD_W +: WORD_W] = words[(NBIAS+s)*WORD_W +: WORD_W];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_drv
    localparam int BASE = drv_base(32'(WIDE_MASK), g, NUM_PINS);
    if (WIDE_MASK[g]) begin : g_wide
      logic [23:0] span;
      assign span = {words[(BASE+1)*WORD_W +: 8], words[BASE*WORD_W +: WORD_W]};
      padcfg_wide_group u_wide (
        .span_i  (span),
        .codes_o (drive_o[g*GRP_PINS*DRV_W +: GRP_PINS*DRV_W])
      );
    end else begin : g_ord
      for (genvar k = 0; k < GRP_PINS; k++) begin : g_pin
        assign drive_o[(g*GRP_PINS+k)*DRV_W +: DRV_W] =
          {1'b0, words[BASE*WORD_W + 2*k +: 2]};
      end
    end
  end
endmodule

// File: rtl/padcfg_bank_chk.sv
module padcfg_bank_chk #(
  parameter int                    NUM_PINS  = 32,
  parameter logic [NUM_PINS/8-1:0] WIDE_MASK = 4'b0110,
  parameter int                    ADDR_W    = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [15:0]           wr_mask,
  input logic [2*NUM_PINS-1:0] bias_o,
  input logic [3*NUM_PINS-1:0] drive_o,
  input logic [NUM_PINS-1:0]   schmitt_o
);
  localparam int NREG  = padcfg_pkg::reg_count(32'(WIDE_MASK), NUM_PINS);
  localparam int NBIAS = NUM_PINS / 8;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bias_o == '0 && drive_o == '0 && schmitt_o == '0)); // R1

  AST_ZERO_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_mask == '0) |=> ($stable(bias_o) && $stable(drive_o) && $stable(schmitt_o))); // R2

  AST_BIAS_WRITE_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) < NBIAS) |=> ($stable(drive_o) && $stable(schmitt_o))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(bias_o) && $stable(drive_o) && $stable(schmitt_o))); // R9

  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) >= NREG) |=> ($stable(bias_o) && $stable(drive_o) && $stable(schmitt_o))); // R9

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_ord
    if (!WIDE_MASK[p/8]) begin : g_chk
      AST_ORD_MSB_ZERO: assert property (@(posedge clk) disable iff (rst)
        drive_o[3*p+2] == 1'b0); // R5
    end
  end
endmodule

bind padcfg_bank padcfg_bank_chk #(
  .NUM_PINS(NUM_PINS), .WIDE_MASK(WIDE_MASK), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_mask(wr_data[31:16]), .bias_o(bias_o), .drive_o(drive_o),
  .schmitt_o(schmitt_o)
);

// File: tb/tb_padcfg_bank.sv
module tb_padcfg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 32;
  localparam logic [3:0] WIDE = 4'b0110;
  localparam int NREG_TB = 12;

  logic          clk = 0;
  logic          rst = 1;
  logic          wr_en = 0;
  logic [3:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [63:0]   bias_o;
  logic [95:0]   drive_o;
  logic [31:0]   schmitt_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] sh [16];
  logic [31:0] lfsr = 32'hACE1_2468;

  always #(CLK_PERIOD/2) clk = ~clk;

  padcfg_bank #(.NUM_PINS(NP), .WIDE_MASK(WIDE), .ADDR_W(4)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bias_o(bias_o), .drive_o(drive_o), .schmitt_o(schmitt_o)
  );

  function automatic int tb_base(input int g);
    int b = 6;
    for (int j = 0; j < g; j++) b += WIDE[j] ? 2 : 1;
    return b;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 16; i++) sh[i] = '0;
  endtask

  task automatic compare(input string tag);
    for (int p = 0; p < NP; p++) begin
      int g = p / 8;
      int k = p % 8;
      int b = tb_base(g);
      logic [1:0] eb;
      logic [2:0] ed;
      logic       es;
      string t;
      eb = {sh[p/8][2*k+1], sh[p/8][2*k]};
      es = sh[4 + p/16][p%16];
      if (WIDE[g]) begin
        for (int i = 0; i < 3; i++) begin
          int L = 3*k + i;
          ed[i] = sh[b + L/16][L%16];
        end
      end else begin
        ed = {1'b0, sh[b][2*k+1], sh[b][2*k]};
      end
      checks += 3;
      t = (tag != "") ? tag : "R3";
      if (bias_o[2*p +: 2] !== eb) begin
        fails++;
        $display("FAIL %s bias pin %0d: got %0d expected %0d", t, p, bias_o[2*p +: 2], eb);
      end
      t = (tag != "") ? tag : "R4";
      if (schmitt_o[p] !== es) begin
        fails++;
        $display("FAIL %s schmitt pin %0d: got %0d expected %0d", t, p, schmitt_o[p], es);
      end
      if (tag != "") t = tag;
      else if (!WIDE[g]) t = "R5";
      else if (k < 5) t = "R6";
      else if (k == 5) t = "R7";
      else t = "R8";
      if (drive_o[3*p +: 3] !== ed) begin
        fails++;
        $display("FAIL %s drive pin %0d: got %0d expected %0d", t, p, drive_o[3*p +: 3], ed);
      end
    end
  endtask

  // R10: write captured at one edge, checked at the following falling edge
  task automatic do_write(input logic [3:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (int'(a) < NREG_TB) sh[a] = (sh[a] & ~d[31:16]) | (d[15:0] & d[31:16]);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare("R1");

    do_write(4'd1, {16'h000C, 16'h0008}, "R3");       // pin 9 pull-down
    do_write(4'd4, {16'h0020, 16'hFFFF}, "R4");       // pin 5 schmitt
    do_write(4'd6, {16'h00C0, 16'h0080}, "R5");       // pin 3 drive 2
    do_write(4'd7, {16'h8000, 16'h8000}, "R7");       // pin 13 bit0
    do_write(4'd8, {16'h0003, 16'h0002}, "R7");       // pin 13 bits 2:1 -> 5
    do_write(4'd7, {16'h0000, 16'hFFFF}, "R2");       // zero enable
    do_write(4'd8, {16'h0001, 16'hFFFF}, "R2");       // partial enable -> 7
    do_write(4'd13, {16'hFFFF, 16'hFFFF}, "R9");      // unmapped
    do_write(4'd10, {16'h00FC, 16'h0024}, "R8");      // pins 22,23

    // strobe low with live data: nothing moves
    @(negedge clk);
    wr_addr = 4'd0; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    compare("R9");

    // sweep every address with pseudo-random value and enable patterns
    for (int rep = 0; rep < 20; rep++) begin
      for (int a = 0; a < 16; a++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        do_write(4'(a), lfsr ^ {lfsr[15:0], lfsr[31:16]}, "");
      end
    end

    // reset in the middle of a populated state
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    clear_model();
    @(negedge clk);
    compare("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule